// File: doc/BRIEF.md
# Pairwise XOR Coded Read Scheduler

This block serves many reads per cycle from a memory region built out of single-port banks. The region has four data banks, numbered 0 to 3, and six shallow parity banks. Each parity bank holds, row by row, the XOR of one pair of data banks. Parity exists only for the lower `SHALLOW` rows. Every cycle the scheduler takes up to `SLOTS` pending read requests. Each request is a bank id and a row index. The scheduler picks which requests to serve, and one cycle later it returns a served flag and the data for each slot.

A request is served in one of two ways. It can be read directly from its own data bank. It can also be rebuilt by XORing a parity row with the same row of a partner data bank, which is a degraded read. A partner row that has already been fetched can feed several degraded reads in the same cycle. This lets several requests aimed at one bank complete together, which raises the best case to ten reads per cycle. Writes are not part of this block. The bank contents are a fixed pattern loaded at reset.

Top module: `xor_coded_read_sched`

## Requirements
- R1: At reset, row r of data bank k is loaded with the low `WORD_W` bits of (37*r + 101*k + 29). The parity bank for pair {x,y} holds the XOR of rows x and y for rows 0 to `SHALLOW`-1 only. A served request returns exactly the data-bank word it names.
- R2: The served flags and data for the requests presented before a clock edge appear right after that edge. While reset is active, and in the first cycle after it, all served flags and all data are zero.
- R3: For each data bank, the lowest-numbered valid slot that targets it is always served directly from that bank.
- R4: Each data bank and each parity bank is accessed at most once per cycle. Requests that cannot be scheduled within that limit are not served.
- R5: After the direct assignment, the remaining valid requests are taken in ascending slot order. Each one is first served through a free parity bank pairing it with a data bank that is already fetched at the same row. Partners are tried in ascending bank id.
- R6: If no fetched partner fits, the request claims the lowest-id free data bank whose parity bank with it is also free. That data bank is then fetched at the request's row and can serve later slots as a fetched partner.
- R7: A request whose row is at or above `SHALLOW` is served only directly, never through parity.
- R8: When every slot requests the same row below `SHALLOW`, and the requests cover banks 0,1,2,3,0,0,0,1,1,2, all ten slots are served in one cycle.
- R9: A slot that is not served outputs a zero served flag and zero data.
- R10: A slot whose valid bit is low is never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the bank contents |
| req_valid | input | SLOTS | Per-slot request valid; slot 0 is the oldest |
| req_bank | input | SLOTS x 2 | Per-slot target data bank id (0 to 3) |
| req_row | input | SLOTS x clog2(ROWS) | Per-slot row index |
| rsp_served | output | SLOTS | Per-slot served flag, one cycle after the request |
| rsp_data | output | SLOTS x WORD_W | Per-slot read data, zero when not served |

## Verification
The hardest state to reach is a cycle where a data bank first claimed as a fallback partner is then reused as a fetched partner by a later slot. In that same cycle some parity pairs must already be taken, so that the choice of partner order decides which slots are served. Directed patterns cannot cover this well. The bench therefore sweeps a few thousand pseudo-random request sets drawn from a narrow row range that straddles the shallow boundary, and compares every slot against an arithmetic model of the greedy rules. It adds full-row sweeps that touch every parity word and the ten-read best case.

// File: rtl/xcr_pkg.sv
package xcr_pkg;

    parameter int NUM_SLOTS    = 10;
    parameter int DATA_ROWS    = 16;
    parameter int SHALLOW_ROWS = 8;
    parameter int DATA_WIDTH   = 16;

    localparam int DBANKS   = 4;
    localparam int PBANKS   = 6;
    localparam int ROW_BITS = $clog2(DATA_ROWS);

    typedef logic [1:0] bank_t;
    typedef logic [2:0] pidx_t;

    typedef struct packed {
        logic  served;
        logic  degraded;
        bank_t home;
        bank_t partner;
        pidx_t par;
    } route_t;

    // parity bank index for an unordered pair of data banks
    function automatic pidx_t pair_idx(bank_t x, bank_t y);
        logic [3:0] key;
        key = (x < y) ? {x, y} : {y, x};
        case (key)
            4'b0001: return 3'd0;
            4'b0010: return 3'd1;
            4'b0011: return 3'd2;
            4'b0110: return 3'd3;
            4'b0111: return 3'd4;
            4'b1011: return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic bank_t pair_lo(pidx_t p);
        case (p)
            3'd0, 3'd1, 3'd2: return 2'd0;
            3'd3, 3'd4:       return 2'd1;
            default:          return 2'd2;
        endcase
    endfunction

    function automatic bank_t pair_hi(pidx_t p);
        case (p)
            3'd0:       return 2'd1;
            3'd1, 3'd3: return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

    function automatic logic [31:0] fill_word(int unsigned bank, int unsigned row);
        return 32'(row * 37 + bank * 101 + 29);
    endfunction

endpackage

// File: rtl/coded_bank.sv
module coded_bank
    import xcr_pkg::*;
#(
    parameter int DEPTH     = DATA_ROWS,
    parameter int ROW_W     = ROW_BITS,
    parameter int WORD_W    = DATA_WIDTH,
    parameter bit IS_PARITY = 1'b0,
    parameter int ID        = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ROW_W-1:0]  addr,
    output logic [WORD_W-1:0] q
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] mem [DEPTH];

    function automatic logic [WORD_W-1:0] init_word(int unsigned r);
        logic [31:0] w;
        if (IS_PARITY)
            w = fill_word(32'(pair_lo(pidx_t'(ID))), r) ^
                fill_word(32'(pair_hi(pidx_t'(ID))), r);
        else
            w = fill_word(ID, r);
        return w[WORD_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < DEPTH; r++) mem[r] <= init_word(r);
            q <= '0;
        end else if (en) begin
            q <= mem[addr[AW-1:0]];
        end
    end

    // single-port row bound: a shallow bank is never addressed past its depth
    p_bank_range_r7: assert property (@(posedge clk) disable iff (rst)
        en |-> (32'(addr) < DEPTH));

endmodule

// File: rtl/xcr_sched.sv
module xcr_sched
    import xcr_pkg::*;
#(
    parameter int SLOTS   = NUM_SLOTS,
    parameter int ROW_W   = ROW_BITS,
    parameter int SHALLOW = SHALLOW_ROWS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [SLOTS-1:0]                  valid,
    input  logic [SLOTS-1:0][1:0]             bank,
    input  logic [SLOTS-1:0][ROW_W-1:0]       row,
    output route_t [SLOTS-1:0]                route,
    output logic [DBANKS-1:0]                 d_en,
    output logic [DBANKS-1:0][ROW_W-1:0]      d_addr,
    output logic [PBANKS-1:0]                 p_en,
    output logic [PBANKS-1:0][ROW_W-1:0]      p_addr
);
    logic  found;
    bank_t yb;
    pidx_t pi;

    always_comb begin
        route  = '0;
        d_en   = '0;
        d_addr = '0;
        p_en   = '0;
        p_addr = '0;
        found  = 1'b0;
        yb     = '0;
        pi     = '0;
        // pass one: oldest request per data bank goes direct
        for (int s = 0; s < SLOTS; s++) begin
            if (valid[s] && !d_en[bank[s]]) begin
                d_en[bank[s]]   = 1'b1;
                d_addr[bank[s]] = row[s];
                route[s].served = 1'b1;
                route[s].home   = bank[s];
            end
        end
        // pass two: degraded reads in slot order
        for (int s = 0; s < SLOTS; s++) begin
            if (valid[s] && !route[s].served && (32'(row[s]) < SHALLOW)) begin
                found = 1'b0;
                for (int y = 0; y < DBANKS; y++) begin
                    yb = bank_t'(y);
                    pi = pair_idx(bank[s], yb);
                    if (!found && yb != bank[s] && d_en[y] &&
                        d_addr[y] == row[s] && !p_en[pi]) begin
                        found     = 1'b1;
                        p_en[pi]  = 1'b1;
                        p_addr[pi] = row[s];
                        route[s]  = '{served: 1'b1, degraded: 1'b1,
                                      home: bank[s], partner: yb, par: pi};
                    end
                end
                for (int y = 0; y < DBANKS; y++) begin
                    yb = bank_t'(y);
                    pi = pair_idx(bank[s], yb);
                    if (!found && yb != bank[s] && !d_en[y] && !p_en[pi]) begin
                        found      = 1'b1;
                        d_en[y]    = 1'b1;
                        d_addr[y]  = row[s];
                        p_en[pi]   = 1'b1;
                        p_addr[pi] = row[s];
                        route[s]   = '{served: 1'b1, degraded: 1'b1,
                                       home: bank[s], partner: yb, par: pi};
                    end
                end
            end
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_chk
        p_partner_row_r5: assert property (@(posedge clk) disable iff (rst)
            (route[s].served && route[s].degraded) |->
            (d_en[route[s].partner] && d_addr[route[s].partner] == row[s] &&
             p_en[route[s].par] && p_addr[route[s].par] == row[s]));
    end

endmodule

// File: rtl/xor_coded_read_sched.sv
module xor_coded_read_sched
    import xcr_pkg::*;
#(
    parameter int SLOTS   = NUM_SLOTS,
    parameter int ROWS    = DATA_ROWS,
    parameter int SHALLOW = SHALLOW_ROWS,
    parameter int WORD_W  = DATA_WIDTH
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [SLOTS-1:0]                       req_valid,
    input  logic [SLOTS-1:0][1:0]                  req_bank,
    input  logic [SLOTS-1:0][$clog2(ROWS)-1:0]     req_row,
    output logic [SLOTS-1:0]                       rsp_served,
    output logic [SLOTS-1:0][WORD_W-1:0]           rsp_data
);
    localparam int ROW_W = $clog2(ROWS);

    route_t [SLOTS-1:0]              route, route_q;
    logic   [SLOTS-1:0][ROW_W-1:0]   row_q;
    logic   [DBANKS-1:0]             d_en;
    logic   [DBANKS-1:0][ROW_W-1:0]  d_addr;
    logic   [PBANKS-1:0]             p_en;
    logic   [PBANKS-1:0][ROW_W-1:0]  p_addr;
    logic   [DBANKS-1:0][WORD_W-1:0] dq;
    logic   [PBANKS-1:0][WORD_W-1:0] pq;

    xcr_sched #(.SLOTS(SLOTS), .ROW_W(ROW_W), .SHALLOW(SHALLOW)) u_sched (
        .clk(clk), .rst(rst),
        .valid(req_valid), .bank(req_bank), .row(req_row),
        .route(route), .d_en(d_en), .d_addr(d_addr),
        .p_en(p_en), .p_addr(p_addr)
    );

    for (genvar g = 0; g < DBANKS; g++) begin : g_data
        coded_bank #(.DEPTH(ROWS), .ROW_W(ROW_W), .WORD_W(WORD_W),
                     .IS_PARITY(1'b0), .ID(g)) u_bank (
            .clk(clk), .rst(rst), .en(d_en[g]), .addr(d_addr[g]), .q(dq[g]));
    end

    for (genvar g = 0; g < PBANKS; g++) begin : g_par
        coded_bank #(.DEPTH(SHALLOW), .ROW_W(ROW_W), .WORD_W(WORD_W),
                     .IS_PARITY(1'b1), .ID(g)) u_bank (
            .clk(clk), .rst(rst), .en(p_en[g]), .addr(p_addr[g]), .q(pq[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            row_q   <= '0;
        end else begin
            route_q <= route;
            row_q   <= req_row;
        end
    end

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            rsp_served[s] = route_q[s].served;
            if (!route_q[s].served)
                rsp_data[s] = '0;
            else if (route_q[s].degraded)
                rsp_data[s] = dq[route_q[s].partner] ^ pq[route_q[s].par];
            else
                rsp_data[s] = dq[route_q[s].home];
        end
    end

    // ---------------- assertions ----------------
    logic [DBANKS-1:0]      bank_req;
    logic [DBANKS-1:0][3:0] direct_cnt;
    logic [PBANKS-1:0][3:0] par_cnt;

    always_comb begin
        bank_req   = '0;
        direct_cnt = '0;
        par_cnt    = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (req_valid[s]) bank_req[req_bank[s]] = 1'b1;
            if (route_q[s].served && !route_q[s].degraded)
                direct_cnt[route_q[s].home] = direct_cnt[route_q[s].home] + 4'd1;
            if (route_q[s].served && route_q[s].degraded)
                par_cnt[route_q[s].par] = par_cnt[route_q[s].par] + 4'd1;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
        p_served_valid_r10: assert property (@(posedge clk) disable iff (rst)
            rsp_served[s] |-> $past(req_valid[s]));
        p_shallow_direct_r7: assert property (@(posedge clk) disable iff (rst)
            (rsp_served[s] && route_q[s].degraded) |-> (32'(row_q[s]) < SHALLOW));
        p_unserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
            !rsp_served[s] |-> (rsp_data[s] == '0));
    end

    for (genvar b = 0; b < DBANKS; b++) begin : g_bank_chk
        p_direct_oldest_r3: assert property (@(posedge clk) disable iff (rst)
            $past(bank_req[b]) |-> (direct_cnt[b] == 4'd1));
        p_one_direct_r4: assert property (@(posedge clk) disable iff (rst)
            direct_cnt[b] <= 4'd1);
    end

    for (genvar p = 0; p < PBANKS; p++) begin : g_par_chk
        p_one_parity_r4: assert property (@(posedge clk) disable iff (rst)
            par_cnt[p] <= 4'd1);
    end

endmodule

// File: tb/tb_xor_coded_read_sched.sv
module tb_xor_coded_read_sched;
    localparam int SLOTS   = 10;
    localparam int ROWS    = 16;
    localparam int SHALLOW = 8;
    localparam int W       = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [SLOTS-1:0]            vld;
    logic [SLOTS-1:0][1:0]       bnk;
    logic [SLOTS-1:0][3:0]       row;
    logic [SLOTS-1:0]            rsp_served;
    logic [SLOTS-1:0][W-1:0]     rsp_data;

    int checks = 0;
    int fails  = 0;
    logic [SLOTS-1:0] exp_srv;
    int unsigned lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    xor_coded_read_sched #(.SLOTS(SLOTS), .ROWS(ROWS), .SHALLOW(SHALLOW), .WORD_W(W)) dut (
        .clk(clk), .rst(rst), .req_valid(vld), .req_bank(bnk), .req_row(row),
        .rsp_served(rsp_served), .rsp_data(rsp_data));

    function automatic logic [W-1:0] pat(int b, int r);
        int unsigned v;
        v = r * 37 + b * 101 + 29;
        return v[W-1:0];
    endfunction

    // arithmetic model of the greedy rules (R3, R5, R6, R7)
    task automatic model();
        bit used[4];
        int frow[4];
        bit pair_busy[16];
        bit done;
        for (int k = 0; k < 4; k++) begin used[k] = 0; frow[k] = -1; end
        for (int k = 0; k < 16; k++) pair_busy[k] = 0;
        exp_srv = '0;
        for (int s = 0; s < SLOTS; s++)
            if (vld[s] && !used[bnk[s]]) begin
                used[bnk[s]] = 1; frow[bnk[s]] = row[s]; exp_srv[s] = 1;
            end
        for (int s = 0; s < SLOTS; s++) begin
            if (vld[s] && !exp_srv[s] && row[s] < SHALLOW) begin
                done = 0;
                for (int y = 0; y < 4; y++) begin
                    int x = bnk[s];
                    int key = (x < y) ? x * 4 + y : y * 4 + x;
                    if (!done && y != x && used[y] && frow[y] == row[s] && !pair_busy[key]) begin
                        done = 1; pair_busy[key] = 1; exp_srv[s] = 1;
                    end
                end
                for (int y = 0; y < 4; y++) begin
                    int x = bnk[s];
                    int key = (x < y) ? x * 4 + y : y * 4 + x;
                    if (!done && y != x && !used[y] && !pair_busy[key]) begin
                        done = 1; pair_busy[key] = 1; used[y] = 1; frow[y] = row[s];
                        exp_srv[s] = 1;
                    end
                end
            end
        end
    endtask

    task automatic check_slots(string tag);
        logic [W-1:0] e;
        for (int s = 0; s < SLOTS; s++) begin
            e = exp_srv[s] ? pat(bnk[s], row[s]) : '0;
            checks++;
            if (rsp_served[s] !== exp_srv[s] || rsp_data[s] !== e) begin
                fails++;
                $display("FAIL %s slot %0d: served=%b data=%h expected served=%b data=%h",
                         tag, s, rsp_served[s], rsp_data[s], exp_srv[s], e);
            end
        end
    endtask

    // drive after a falling edge, check after the next falling edge (R2 latency)
    task automatic apply(string tag);
        model();
        @(negedge clk);
        check_slots(tag);
    endtask

    task automatic set_slot(int s, bit v, int b, int r);
        vld[s] = v; bnk[s] = 2'(b); row[s] = 4'(r);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        vld = '0; bnk = '0; row = '0;
        repeat (3) @(negedge clk);
        // R2: outputs zero during reset
        checks++;
        if (rsp_served !== '0 || rsp_data !== '0) begin
            fails++;
            $display("FAIL R2 reset: served=%b expected 0", rsp_served);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_served !== '0 || rsp_data !== '0) begin
            fails++;
            $display("FAIL R2 first cycle: served=%b expected 0", rsp_served);
        end

        // R1 / R3: every data word read directly
        for (int r = 0; r < ROWS; r++) begin
            vld = '0;
            for (int b = 0; b < 4; b++) set_slot(b, 1, b, (r + b) % ROWS);
            apply("R1 direct sweep");
        end

        // R1 / R8: all six parity words of every shallow row, ten reads in a cycle
        for (int r = 0; r < SHALLOW; r++) begin
            int bl[10] = '{0, 1, 2, 3, 0, 0, 0, 1, 1, 2};
            for (int s = 0; s < SLOTS; s++) set_slot(s, 1, bl[s], r);
            apply("R8 best case");
            checks++;
            if (rsp_served !== '1) begin
                fails++;
                $display("FAIL R8 row %0d: served=%b expected %b", r, rsp_served, {SLOTS{1'b1}});
            end
        end

        // R6: four reads of bank 0 at distinct rows use free partners 1,2,3; fifth is lost (R4)
        vld = '0;
        for (int s = 0; s < 5; s++) set_slot(s, 1, 0, s + 1);
        apply("R6 free partner");
        checks++;
        if (rsp_served !== 10'b00_0000_1111) begin
            fails++;
            $display("FAIL R4 single access: served=%b expected %b", rsp_served, 10'b00_0000_1111);
        end

        // R4 / R9: no shared row, all data banks busy -> extra read not served
        vld = '0;
        set_slot(0, 1, 0, 10); set_slot(1, 1, 1, 11); set_slot(2, 1, 2, 12);
        set_slot(3, 1, 3, 13); set_slot(4, 1, 0, 1);
        apply("R9 unserved zero");

        // R7: rows at or above the shallow limit never degrade
        vld = '0;
        set_slot(0, 1, 2, SHALLOW); set_slot(1, 1, 2, SHALLOW + 1); set_slot(2, 1, 2, ROWS - 1);
        apply("R7 deep rows");
        checks++;
        if (rsp_served !== 10'b00_0000_0001) begin
            fails++;
            $display("FAIL R7 deep rows: served=%b expected %b", rsp_served, 10'b00_0000_0001);
        end

        // R5: fetched partner preferred over a free one
        vld = '0;
        set_slot(0, 1, 3, 5); set_slot(1, 1, 0, 2); set_slot(2, 1, 0, 5);
        set_slot(3, 1, 1, 2); set_slot(4, 1, 1, 2);
        apply("R5 fetched partner");

        // R10: invalid slots never served, whatever their fields
        vld = '0;
        for (int s = 0; s < SLOTS; s++) set_slot(s, 0, s % 4, 3);
        apply("R10 invalid slots");

        // R3/R5/R6/R7 pseudo-random sweep over a narrow row range
        for (int it = 0; it < 4000; it++) begin
            for (int s = 0; s < SLOTS; s++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                set_slot(s, lcg[31:30] != 2'b00, int'(lcg[25:24]),
                         (it % 3 == 0) ? int'(lcg[19:16]) : 6 + int'(lcg[17:16]));
            end
            apply("R5/R6 random sweep");
        end

        summary();
        $finish;
    end
endmodule